// File: doc/BRIEF.md
# Parser Stage Bus Realigner

The realigner closes each stage of a streaming header parser. A stage sees a packet as a series of bus beats, and the header it handles starts at byte lane 0 of the first beat. Once that header has been consumed, the next stage needs the bytes that follow it to start at lane 0 as well. The realigner removes the consumed header bytes from the stream. It keeps one earlier beat in a register and joins it with the beat now arriving. A byte funnel then picks the bus-width window that starts just after the header. Whole beats that are covered by a long header are dropped before any data is sent. When the remaining payload does not fill the last joined beat, one extra flush beat carries the leftover bytes out.

The header length is either a build-time constant or a function of a size code that the extractor supplies with the packet's first beat. For the size code, a table computed at elaboration turns each code into a count of dropped beats and a lane offset. The result is registered once per packet. When the stage's header is absent from a packet, the block passes every byte through unchanged. Packet start and end markers, the packet tag and a valid-byte count on the final beat travel with the data.

Top module: `stage_realigner`

## Requirements
- R1: After reset, out_valid stays low until the first realigned beat of a packet is produced.
- R2: The output byte stream of a packet equals the input bytes from byte offset H to the end, in order. Byte lane k is bits [8k+7:8k], and lane 0 is the earliest byte on the wire.
- R3: With VAR_SIZE=1, H = in_size_code * SIZE_UNIT. in_size_code and in_hdr_valid are sampled only on the beat that carries in_sop. Their values on later beats have no effect.
- R4: With VAR_SIZE=0, H = FIXED_HDR_BYTES whatever in_size_code carries.
- R5: When in_hdr_valid is low on the start beat, H is taken as 0. Every byte is forwarded unchanged, with the same beat boundaries, and the size code is ignored.
- R6: Every output beat except the last of a packet carries BUS_BYTES bytes. The last beat carries out_eop and an out_bytes count from 1 to BUS_BYTES.
- R7: The final output beat of a packet appears by the second clock edge after the input beat carrying in_eop is sampled. A combined beat and a flush beat never fall in the same cycle.
- R8: out_sop marks the first output beat of each packet. out_id equals the in_id sampled with in_sop on every beat of that packet.
- R9: A packet whose start beat directly follows the previous packet's end beat produces output that contains only its own bytes.
- R10: Idle cycles (in_valid low) between the beats of a packet do not change its output bytes or beat boundaries.
- R11: A header longer than one bus beat drops whole beats and then applies the lane offset H mod BUS_BYTES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_data | input | 8*BUS_BYTES | Input beat, lane 0 first |
| in_sop | input | 1 | First beat of a packet |
| in_eop | input | 1 | Last beat of a packet |
| in_bytes | input | $clog2(BUS_BYTES+1) | Valid bytes on the last beat (1..BUS_BYTES) |
| in_id | input | ID_W | Packet tag, sampled with in_sop |
| in_hdr_valid | input | 1 | Header of this stage present, sampled with in_sop |
| in_size_code | input | CODE_W | Header size code, sampled with in_sop |
| out_valid | output | 1 | Output beat present |
| out_data | output | 8*BUS_BYTES | Realigned beat; lanes beyond out_bytes are undefined |
| out_sop | output | 1 | First output beat of a packet |
| out_eop | output | 1 | Last output beat of a packet |
| out_bytes | output | $clog2(BUS_BYTES+1) | Valid bytes in the beat |
| out_id | output | ID_W | Packet tag |

## Verification
The properties assume well-framed input. Every packet runs from a start beat to an end beat, no beat arrives outside a packet, and the end beat's byte count lies between 1 and BUS_BYTES. When the header is present, the packet is longer than its header, so at least one byte remains. The stimulus builds each packet from a length chosen above the larger of the two header sizes in use, draws byte counts only from that range, and starts a new packet only after an end beat. It mixes back-to-back packets, idle gaps and garbage on the sampled-once fields, and a reference model in the bench predicts every output beat.

// File: rtl/stage_realign_pkg.sv
package stage_realign_pkg;

   // Header length in bytes for a size code.
   function automatic int hdr_len_of(input int code, input int unit);
      return code * unit;
   endfunction

   // Whole bus beats covered by a header.
   function automatic int drop_beats_of(input int hdr_len, input int bus_bytes);
      return hdr_len / bus_bytes;
   endfunction

   // Lane offset of the first byte after the header.
   function automatic int lane_shift_of(input int hdr_len, input int bus_bytes);
      return hdr_len % bus_bytes;
   endfunction

endpackage

// File: rtl/realign_shift_src.sv
module realign_shift_src
   import stage_realign_pkg::*;
#(
   parameter int BUS_BYTES       = 8,
   parameter int VAR_SIZE        = 1,
   parameter int FIXED_HDR_BYTES = 6,
   parameter int CODE_W          = 4,
   parameter int SIZE_UNIT       = 4,
   parameter int DROP_W          = 4,
   parameter int SHIFT_W         = 3
) (
   input  logic [CODE_W-1:0]  size_code,
   output logic [DROP_W-1:0]  drop_beats,
   output logic [SHIFT_W-1:0] shift_bytes
);

   if (VAR_SIZE != 0) begin : g_table
      localparam int ENTRIES = 1 << CODE_W;
      logic [DROP_W-1:0]  tbl_drop  [ENTRIES];
      logic [SHIFT_W-1:0] tbl_shift [ENTRIES];

      for (genvar c = 0; c < ENTRIES; c++) begin : g_entry
         assign tbl_drop[c]  = DROP_W'(drop_beats_of(hdr_len_of(c, SIZE_UNIT), BUS_BYTES));
         assign tbl_shift[c] = SHIFT_W'(lane_shift_of(hdr_len_of(c, SIZE_UNIT), BUS_BYTES));
      end

      assign drop_beats  = tbl_drop[size_code];
      assign shift_bytes = tbl_shift[size_code];
   end else begin : g_const
      localparam int FDROP  = drop_beats_of(FIXED_HDR_BYTES, BUS_BYTES);
      localparam int FSHIFT = lane_shift_of(FIXED_HDR_BYTES, BUS_BYTES);
      logic unused_code;
      assign unused_code = ^size_code;
      assign drop_beats  = DROP_W'(FDROP);
      assign shift_bytes = SHIFT_W'(FSHIFT);
   end

endmodule

// File: rtl/realign_ctrl.sv
module realign_ctrl #(
   parameter int BUS_BYTES = 8,
   parameter int DROP_W    = 4,
   parameter int SHIFT_W   = 3,
   parameter int CNT_W     = 4,
   parameter int ID_W      = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic               in_sop,
   input  logic               in_eop,
   input  logic [CNT_W-1:0]   in_bytes,
   input  logic [ID_W-1:0]    in_id,
   input  logic               in_hdr_valid,
   input  logic [DROP_W-1:0]  tbl_drop,
   input  logic [SHIFT_W-1:0] tbl_shift,
   output logic               emit,
   output logic [CNT_W-1:0]   emit_bytes,
   output logic               emit_sop,
   output logic               emit_eop,
   output logic               flush,
   output logic [CNT_W-1:0]   flush_bytes,
   output logic               flush_sop,
   output logic [SHIFT_W-1:0] cur_shift,
   output logic [ID_W-1:0]    cur_id
);

   localparam logic [DROP_W-1:0] BEAT_SAT = {DROP_W{1'b1}};

   logic [DROP_W-1:0]  drop_q;
   logic [SHIFT_W-1:0] shift_q;
   logic [ID_W-1:0]    id_q;
   logic [DROP_W-1:0]  beat_q;
   logic               first_q;
   logic               flush_q;
   logic [CNT_W-1:0]   fbytes_q;
   logic               fsop_q;

   logic [DROP_W-1:0]  eff_drop;
   logic [SHIFT_W-1:0] eff_shift;
   logic [CNT_W-1:0]   shift_ext;
   logic [CNT_W-1:0]   eff_ext;
   logic               need_flush;
   logic               last_short;

   // A start beat loads new per-packet settings; an absent header means no shift.
   assign eff_drop  = in_sop ? (in_hdr_valid ? tbl_drop  : '0) : drop_q;
   assign eff_shift = in_sop ? (in_hdr_valid ? tbl_shift : '0) : shift_q;
   assign shift_ext = CNT_W'(shift_q);
   assign eff_ext   = CNT_W'(eff_shift);

   // A joined beat is ready once the covered beats have passed.
   assign emit       = in_valid & ~in_sop & (beat_q > drop_q);
   assign last_short = in_eop & (in_bytes < shift_ext);
   assign emit_eop   = emit & in_eop & (in_bytes <= shift_ext);
   assign emit_bytes = last_short ? (CNT_W'(BUS_BYTES) - (shift_ext - in_bytes))
                                  : CNT_W'(BUS_BYTES);
   assign emit_sop   = first_q;
   assign need_flush = in_valid & in_eop & (in_bytes > eff_ext);

   assign flush       = flush_q;
   assign flush_bytes = fbytes_q;
   assign flush_sop   = fsop_q;
   assign cur_shift   = shift_q;
   assign cur_id      = id_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drop_q   <= '0;
         shift_q  <= '0;
         id_q     <= '0;
         beat_q   <= '0;
         first_q  <= 1'b0;
         flush_q  <= 1'b0;
         fbytes_q <= '0;
         fsop_q   <= 1'b0;
      end else begin
         flush_q <= need_flush;
         if (need_flush) begin
            fbytes_q <= in_bytes - eff_ext;
            fsop_q   <= in_sop | (first_q & ~emit);
         end
         if (in_valid) begin
            if (in_sop) begin
               drop_q  <= eff_drop;
               shift_q <= eff_shift;
               id_q    <= in_id;
               beat_q  <= DROP_W'(1);
               first_q <= 1'b1;
            end else begin
               if (beat_q != BEAT_SAT) beat_q <= beat_q + DROP_W'(1);
               if (emit) first_q <= 1'b0;
            end
         end
      end
   end

endmodule

// File: rtl/realign_datapath.sv
module realign_datapath #(
   parameter int BUS_BYTES = 8,
   parameter int SHIFT_W   = 3,
   parameter int CNT_W     = 4,
   parameter int ID_W      = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic [8*BUS_BYTES-1:0] in_data,
   input  logic                   emit,
   input  logic [CNT_W-1:0]       emit_bytes,
   input  logic                   emit_sop,
   input  logic                   emit_eop,
   input  logic                   flush,
   input  logic [CNT_W-1:0]       flush_bytes,
   input  logic                   flush_sop,
   input  logic [SHIFT_W-1:0]     cur_shift,
   input  logic [ID_W-1:0]        cur_id,
   output logic                   out_valid,
   output logic [8*BUS_BYTES-1:0] out_data,
   output logic                   out_sop,
   output logic                   out_eop,
   output logic [CNT_W-1:0]       out_bytes,
   output logic [ID_W-1:0]        out_id
);

   localparam int DATA_W = 8 * BUS_BYTES;

   logic [DATA_W-1:0]   prev_q;
   logic [2*DATA_W-1:0] pair;
   logic [DATA_W-1:0]   shifted;

   // A flush drains the held beat alone, so the upper half is empty.
   assign pair = {(flush ? {DATA_W{1'b0}} : in_data), prev_q};

   for (genvar k = 0; k < BUS_BYTES; k++) begin : g_lane
      assign shifted[8*k +: 8] = pair[8*(32'(cur_shift) + k) +: 8];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q    <= '0;
         out_valid <= 1'b0;
         out_data  <= '0;
         out_sop   <= 1'b0;
         out_eop   <= 1'b0;
         out_bytes <= '0;
         out_id    <= '0;
      end else begin
         if (in_valid) prev_q <= in_data;
         out_valid <= flush | emit;
         if (flush) begin
            out_data  <= shifted;
            out_sop   <= flush_sop;
            out_eop   <= 1'b1;
            out_bytes <= flush_bytes;
            out_id    <= cur_id;
         end else if (emit) begin
            out_data  <= shifted;
            out_sop   <= emit_sop;
            out_eop   <= emit_eop;
            out_bytes <= emit_bytes;
            out_id    <= cur_id;
         end
      end
   end

endmodule

// File: rtl/stage_realigner.sv
module stage_realigner
   import stage_realign_pkg::*;
#(
   parameter int BUS_BYTES       = 8,
   parameter int VAR_SIZE        = 1,
   parameter int FIXED_HDR_BYTES = 6,
   parameter int CODE_W          = 4,
   parameter int SIZE_UNIT       = 4,
   parameter int ID_W            = 8
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 in_valid,
   input  logic [8*BUS_BYTES-1:0]               in_data,
   input  logic                                 in_sop,
   input  logic                                 in_eop,
   input  logic [$clog2(BUS_BYTES+1)-1:0]       in_bytes,
   input  logic [ID_W-1:0]                      in_id,
   input  logic                                 in_hdr_valid,
   input  logic [CODE_W-1:0]                    in_size_code,
   output logic                                 out_valid,
   output logic [8*BUS_BYTES-1:0]               out_data,
   output logic                                 out_sop,
   output logic                                 out_eop,
   output logic [$clog2(BUS_BYTES+1)-1:0]       out_bytes,
   output logic [ID_W-1:0]                      out_id
);

   localparam int SHIFT_W  = $clog2(BUS_BYTES);
   localparam int CNT_W    = $clog2(BUS_BYTES + 1);
   localparam int MAX_HDR  = (VAR_SIZE != 0) ? ((1 << CODE_W) - 1) * SIZE_UNIT : FIXED_HDR_BYTES;
   localparam int MAX_DROP = drop_beats_of(MAX_HDR, BUS_BYTES);
   localparam int DROP_W   = $clog2(MAX_DROP + 2);

   if (BUS_BYTES < 2 || (BUS_BYTES & (BUS_BYTES - 1)) != 0) begin : g_bad_bus
      $error("BUS_BYTES must be a power of two of at least 2");
   end
   if (VAR_SIZE == 0 && FIXED_HDR_BYTES < 0) begin : g_bad_fixed
      $error("FIXED_HDR_BYTES must not be negative");
   end
   if (VAR_SIZE != 0 && (SIZE_UNIT < 1 || CODE_W < 1 || CODE_W > 8)) begin : g_bad_code
      $error("size code needs 1..8 bits and a positive unit");
   end
   if (ID_W < 1) begin : g_bad_id
      $error("ID_W must be positive");
   end

   logic [DROP_W-1:0]  tbl_drop;
   logic [SHIFT_W-1:0] tbl_shift;
   logic               ctl_emit;
   logic [CNT_W-1:0]   ctl_emit_bytes;
   logic               ctl_emit_sop;
   logic               ctl_emit_eop;
   logic               ctl_flush;
   logic [CNT_W-1:0]   ctl_flush_bytes;
   logic               ctl_flush_sop;
   logic [SHIFT_W-1:0] ctl_shift;
   logic [ID_W-1:0]    ctl_id;

   realign_shift_src #(
      .BUS_BYTES(BUS_BYTES), .VAR_SIZE(VAR_SIZE), .FIXED_HDR_BYTES(FIXED_HDR_BYTES),
      .CODE_W(CODE_W), .SIZE_UNIT(SIZE_UNIT), .DROP_W(DROP_W), .SHIFT_W(SHIFT_W)
   ) u_src (
      .size_code   (in_size_code),
      .drop_beats  (tbl_drop),
      .shift_bytes (tbl_shift)
   );

   realign_ctrl #(
      .BUS_BYTES(BUS_BYTES), .DROP_W(DROP_W), .SHIFT_W(SHIFT_W), .CNT_W(CNT_W), .ID_W(ID_W)
   ) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_valid     (in_valid),
      .in_sop       (in_sop),
      .in_eop       (in_eop),
      .in_bytes     (in_bytes),
      .in_id        (in_id),
      .in_hdr_valid (in_hdr_valid),
      .tbl_drop     (tbl_drop),
      .tbl_shift    (tbl_shift),
      .emit         (ctl_emit),
      .emit_bytes   (ctl_emit_bytes),
      .emit_sop     (ctl_emit_sop),
      .emit_eop     (ctl_emit_eop),
      .flush        (ctl_flush),
      .flush_bytes  (ctl_flush_bytes),
      .flush_sop    (ctl_flush_sop),
      .cur_shift    (ctl_shift),
      .cur_id       (ctl_id)
   );

   realign_datapath #(
      .BUS_BYTES(BUS_BYTES), .SHIFT_W(SHIFT_W), .CNT_W(CNT_W), .ID_W(ID_W)
   ) u_dp (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .in_data     (in_data),
      .emit        (ctl_emit),
      .emit_bytes  (ctl_emit_bytes),
      .emit_sop    (ctl_emit_sop),
      .emit_eop    (ctl_emit_eop),
      .flush       (ctl_flush),
      .flush_bytes (ctl_flush_bytes),
      .flush_sop   (ctl_flush_sop),
      .cur_shift   (ctl_shift),
      .cur_id      (ctl_id),
      .out_valid   (out_valid),
      .out_data    (out_data),
      .out_sop     (out_sop),
      .out_eop     (out_eop),
      .out_bytes   (out_bytes),
      .out_id      (out_id)
   );

endmodule

// File: rtl/stage_realigner_chk.sv
module stage_realigner_chk #(
   parameter int BUS_BYTES = 8,
   parameter int ID_W      = 8,
   parameter int CNT_W     = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_eop,
   input logic             out_valid,
   input logic             out_sop,
   input logic             out_eop,
   input logic [CNT_W-1:0] out_bytes,
   input logic [ID_W-1:0]  out_id,
   input logic             emit,
   input logic             flush
);

   logic            open_q;
   logic [ID_W-1:0] id_q;
   logic [1:0]      hist_q;
   logic [2:0]      owe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         id_q   <= '0;
         hist_q <= '0;
         owe_q  <= '0;
      end else begin
         hist_q <= {hist_q[0], in_valid & in_eop};
         owe_q  <= owe_q + 3'(in_valid & in_eop) - 3'(out_valid & out_eop);
         if (out_valid) begin
            open_q <= ~out_eop;
            id_q   <= out_id;
         end
      end
   end

   assert_full_mid_beat_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_eop |-> out_bytes == CNT_W'(BUS_BYTES));

   assert_count_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_bytes != '0) && (out_bytes <= CNT_W'(BUS_BYTES)));

   assert_sop_opens_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !open_q |-> out_sop);

   assert_tag_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && open_q |-> !out_sop && out_id == id_q);

   assert_eop_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
      owe_q <= 3'($countones(hist_q)));

   assert_no_collision_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(emit && flush));

endmodule

bind stage_realigner stage_realigner_chk #(
   .BUS_BYTES(BUS_BYTES), .ID_W(ID_W), .CNT_W($clog2(BUS_BYTES + 1))
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_eop    (in_eop),
   .out_valid (out_valid),
   .out_sop   (out_sop),
   .out_eop   (out_eop),
   .out_bytes (out_bytes),
   .out_id    (out_id),
   .emit      (ctl_emit),
   .flush     (ctl_flush)
);

// File: tb/stage_realigner_tb.sv
module stage_realigner_tb;

   localparam int B     = 8;
   localparam int FIXH  = 6;
   localparam int UNIT  = 4;

   typedef struct packed {
      logic [63:0] data;
      logic [3:0]  cnt;
      logic        sop;
      logic        eop;
      logic [7:0]  id;
   } beat_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic        in_valid = 1'b0;
   logic [63:0] in_data = '0;
   logic        in_sop = 1'b0;
   logic        in_eop = 1'b0;
   logic [3:0]  in_bytes = 4'd8;
   logic [7:0]  in_id = '0;
   logic        in_hdr_valid = 1'b0;
   logic [3:0]  in_size_code = '0;

   logic        v_valid, v_sop, v_eop, f_valid, f_sop, f_eop;
   logic [63:0] v_data, f_data;
   logic [3:0]  v_bytes, f_bytes;
   logic [7:0]  v_id, f_id;

   stage_realigner #(.BUS_BYTES(B), .VAR_SIZE(1), .CODE_W(4), .SIZE_UNIT(UNIT), .ID_W(8)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_sop(in_sop),
      .in_eop(in_eop), .in_bytes(in_bytes), .in_id(in_id), .in_hdr_valid(in_hdr_valid),
      .in_size_code(in_size_code), .out_valid(v_valid), .out_data(v_data), .out_sop(v_sop),
      .out_eop(v_eop), .out_bytes(v_bytes), .out_id(v_id));

   stage_realigner #(.BUS_BYTES(B), .VAR_SIZE(0), .FIXED_HDR_BYTES(FIXH), .CODE_W(4), .ID_W(8)) u_fix (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_sop(in_sop),
      .in_eop(in_eop), .in_bytes(in_bytes), .in_id(in_id), .in_hdr_valid(in_hdr_valid),
      .in_size_code(in_size_code), .out_valid(f_valid), .out_data(f_data), .out_sop(f_sop),
      .out_eop(f_eop), .out_bytes(f_bytes), .out_id(f_id));

   int checks = 0;
   int errors = 0;
   string cur_req = "R1";
   logic [7:0] pkt_mem [0:255];
   beat_t q_var[$];
   beat_t q_fix[$];

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Reference: split bytes [hdr..len-1] into bus beats.
   task automatic expect_pkt(ref beat_t q[$], input int len, input int hdr, input logic [7:0] id);
      int s = len - hdr;
      int nb = (s + B - 1) / B;
      for (int k = 0; k < nb; k++) begin
         beat_t e;
         int c = (s - k*B > B) ? B : s - k*B;
         e.data = '0;
         for (int l = 0; l < c; l++) e.data[8*l +: 8] = pkt_mem[hdr + k*B + l];
         e.cnt = 4'(c);
         e.sop = (k == 0);
         e.eop = (k == nb - 1);
         e.id  = id;
         q.push_back(e);
      end
   endtask

   task automatic compare(ref beat_t q[$], input string inst, input logic [63:0] d,
                          input logic [3:0] c, input logic s, input logic e, input logic [7:0] id);
      beat_t x;
      logic [63:0] m;
      if (q.size() == 0) begin
         check(1'b0, cur_req, {inst, " unexpected beat"}, longint'(d), 0);
         return;
      end
      x = q.pop_front();
      m = '0;
      for (int l = 0; l < 8; l++) if (l < int'(x.cnt)) m[8*l +: 8] = 8'hff;
      check((d & m) == x.data, {cur_req, " R2"}, {inst, " data"}, longint'(d & m), longint'(x.data));
      check(c == x.cnt && e == x.eop, {cur_req, " R6"}, {inst, " count/eop"},
            longint'({c, 3'b0, e}), longint'({x.cnt, 3'b0, x.eop}));
      check(s == x.sop && id == x.id, {cur_req, " R8"}, {inst, " sop/id"},
            longint'({s, id}), longint'({x.sop, x.id}));
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (v_valid) compare(q_var, "var", v_data, v_bytes, v_sop, v_eop, v_id);
         if (f_valid) compare(q_fix, "fix", f_data, f_bytes, f_sop, f_eop, f_id);
      end
   end

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_sop = 1'b0;
         in_eop = 1'b0;
         in_data = 64'($urandom) << 32 | 64'($urandom);
      end
   endtask

   task automatic send_pkt(input int len, input int code, input bit hv, input logic [7:0] id,
                           input bit gaps);
      int nb = (len + B - 1) / B;
      for (int i = 0; i < len; i++) pkt_mem[i] = 8'($urandom);
      expect_pkt(q_var, len, hv ? code * UNIT : 0, id);
      expect_pkt(q_fix, len, hv ? FIXH : 0, id);
      for (int b = 0; b < nb; b++) begin
         if (gaps && b != 0 && ($urandom % 2 == 0)) idle(1 + $urandom % 3);
         @(negedge clk);
         in_valid = 1'b1;
         in_sop = (b == 0);
         in_eop = (b == nb - 1);
         in_bytes = (b == nb - 1) ? 4'(len - (nb - 1) * B) : 4'(B);
         for (int l = 0; l < B; l++)
            in_data[8*l +: 8] = (b*B + l < len) ? pkt_mem[b*B + l] : 8'($urandom);
         if (b == 0) begin
            in_id = id;
            in_hdr_valid = hv;
            in_size_code = 4'(code);
         end else begin
            // sampled-once fields carry garbage later (R3)
            in_id = 8'($urandom);
            in_hdr_valid = 1'($urandom);
            in_size_code = 4'($urandom);
         end
      end
   endtask

   task automatic drained(input string req);
      idle(3);
      #1;
      check(q_var.size() == 0 && q_fix.size() == 0, req, "queues drained by 2nd edge",
            longint'(q_var.size() + q_fix.size()), 0);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs idle in and right after reset
      check(!v_valid && !f_valid, "R1", "out_valid in reset", longint'({v_valid, f_valid}), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(!v_valid && !f_valid, "R1", "out_valid after reset", longint'({v_valid, f_valid}), 0);

      // R3 and R4: last-beat counts below, equal to and above the lane offset (H=20 -> offset 4)
      cur_req = "R3/R4";
      send_pkt(43, 5, 1'b1, 8'h11, 1'b0); drained("R7");
      send_pkt(44, 5, 1'b1, 8'h12, 1'b0); drained("R7");
      send_pkt(45, 5, 1'b1, 8'h13, 1'b0); drained("R7");
      send_pkt(48, 5, 1'b1, 8'h14, 1'b0); drained("R7");
      // single-beat packet realigned into a flush beat
      send_pkt(7, 1, 1'b1, 8'h15, 1'b0); drained("R7");
      // zero-length header via code 0
      send_pkt(17, 0, 1'b1, 8'h16, 1'b0); drained("R7");

      // R11: header spanning several beats
      cur_req = "R11";
      send_pkt(70, 15, 1'b1, 8'h21, 1'b0); drained("R11");
      send_pkt(64, 4, 1'b1, 8'h22, 1'b0); drained("R11");

      // R5: bypass with junk size codes
      cur_req = "R5";
      send_pkt(1, 9, 1'b0, 8'h31, 1'b0); drained("R5");
      send_pkt(8, 15, 1'b0, 8'h32, 1'b0); drained("R5");
      send_pkt(23, 7, 1'b0, 8'h33, 1'b0); drained("R5");

      // R9: back-to-back packets, mixed modes
      cur_req = "R9";
      for (int p = 0; p < 30; p++) begin
         int code = $urandom % 16;
         int minl = (code * UNIT > FIXH ? code * UNIT : FIXH) + 1;
         send_pkt(minl + $urandom % 60, code, 1'($urandom % 4 != 0), 8'(p + 64), 1'b0);
      end
      drained("R9");

      // R10: idle gaps inside packets
      cur_req = "R10";
      for (int p = 0; p < 30; p++) begin
         int code = $urandom % 16;
         int minl = (code * UNIT > FIXH ? code * UNIT : FIXH) + 1;
         send_pkt(minl + $urandom % 60, code, 1'($urandom % 4 != 0), 8'(p + 128), 1'b1);
         if ($urandom % 2 == 0) idle(1);
      end
      drained("R10");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule